// File: doc/BRIEF.md
# Greedy Cache Configuration Tuner

This controller picks a data-cache configuration for the running workload by measuring it. It walks a small space of set counts, line sizes and associativities one parameter at a time. For each candidate it drives the configuration outputs and pulses a measurement request. It then waits for the energy-delay product (EDP) of that interval. The EDP is average power times the square of the run time, with run time taken as cycles over clock frequency. An external monitor computes it and returns it as an unsigned number over a valid/ready handshake.

The walk is greedy. The set count grows first, then the line size, then the number of ways. Each parameter stops growing at the first step that does not strictly lower the best EDP seen so far. When a parameter is settled, it falls back to its best value before the next parameter is tried. The chosen configuration is a single broadcast value that every cache instance applies at once. A start pulse begins the search again from any state.

Top module: `greedy_cache_tuner`

## Requirements
- R1: After reset the tuner is idle: all configuration codes are 0, done, meas_req and edp_ready are low, and eval_count is 0. A start pulse loads the base configuration (16 sets, 128-byte lines, 1 way) and clears eval_count. meas_req is high in the cycle after start is sampled.
- R2: Configuration encoding: cfg_sets is 0=16, 1=32, 2=64 sets; cfg_line is 0=128, 1=256 bytes; cfg_ways is 0=1, 1=2, 2=4 ways. Code 3 never appears on cfg_sets or cfg_ways.
- R3: meas_req is a one-cycle pulse per candidate. In the next cycle edp_ready rises and stays high until an EDP is accepted (edp_valid and edp_ready both high at a clock edge). No request is issued while edp_ready is high.
- R4: The configuration outputs do not change between a meas_req pulse and the acceptance of that interval's EDP.
- R5: Set phase: after the base, 32 sets is tried. 64 sets is tried only if 32 sets strictly lowered EDP. The set count with the lowest EDP is kept.
- R6: Line phase: with the chosen set count and 1 way, 256-byte lines are tried. They are kept only on a strict EDP decrease; otherwise the line goes back to 128.
- R7: Way phase: with the chosen sets and line, 2 ways is tried. 4 ways is tried only if 2 ways strictly lowered EDP. The best way count is kept.
- R8: An equal EDP is not an improvement, so a tie keeps the smaller configuration. The final configuration is the one with the lowest EDP among those visited.
- R9: eval_count rises by one for each accepted EDP. It never exceeds 6, the largest number of candidates a search can visit.
- R10: At the end of the search, done goes high and the final configuration appears. Both then hold, with meas_req and edp_ready low, until the next start pulse.
- R11: A start pulse in the middle of a search, including while an EDP is awaited, abandons it. The search then begins again from the base configuration with eval_count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) a search |
| edp_valid | input | 1 | EDP value for the current interval is present |
| edp_value | input | EDP_W | Measured EDP, unsigned |
| edp_ready | output | 1 | Tuner is waiting for an EDP value |
| meas_req | output | 1 | One-cycle pulse: start a measurement interval |
| cfg_sets | output | 2 | Set-count code broadcast to the caches |
| cfg_line | output | 1 | Line-size code broadcast to the caches |
| cfg_ways | output | 2 | Associativity code broadcast to the caches |
| done | output | 1 | Search finished, configuration final |
| eval_count | output | CNT_W | Number of configurations evaluated |

## Verification
The hardest situations to reach are the deep ends of the walk: 64 sets and 4 ways. Each needs two strict improvements in a row within its phase. With random small EDP values, ties are frequent, and ties cut the walk short. The stimulus mixes random EDP tables over the 18 configurations (values 0 to 15, so the tie rule is exercised often) with directed tables. One directed table falls strictly with every parameter increase and so forces the full six-step walk. One is flat and so forces the shortest walk. A restart is issued while an EDP is outstanding, both in a directed case and in a random subset of trials.

// File: rtl/cache_tuner_pkg.sv
package cache_tuner_pkg;

   typedef struct packed {
      logic [1:0] sets;
      logic       line;
      logic [1:0] ways;
   } cache_cfg_t;

   typedef enum logic [1:0] {
      PH_BASE = 2'd0,
      PH_SETS = 2'd1,
      PH_LINE = 2'd2,
      PH_WAYS = 2'd3
   } tune_phase_t;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LAUNCH = 2'd1,
      ST_WAIT   = 2'd2,
      ST_DONE   = 2'd3
   } tune_state_t;

   localparam cache_cfg_t CFG_BASE = '0;

endpackage

// File: rtl/edp_best_tracker.sv
module edp_best_tracker
   import cache_tuner_pkg::*;
#(
   parameter int EDP_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             take,
   input  logic [EDP_W-1:0] edp_value,
   input  cache_cfg_t       cur_cfg,
   output logic             improved,
   output cache_cfg_t       win_cfg
);

   logic             have_best;
   logic [EDP_W-1:0] best_edp;
   cache_cfg_t       best_cfg;

   // strict comparison: an equal EDP never displaces the earlier, smaller config
   assign improved = !have_best || (edp_value < best_edp);
   assign win_cfg  = improved ? cur_cfg : best_cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_best <= 1'b0;
         best_edp  <= '0;
         best_cfg  <= CFG_BASE;
      end else if (clear) begin
         have_best <= 1'b0;
         best_edp  <= '0;
         best_cfg  <= CFG_BASE;
      end else if (take && improved) begin
         have_best <= 1'b1;
         best_edp  <= edp_value;
         best_cfg  <= cur_cfg;
      end
   end

   // R8: the recorded best never grows once a first value is held
   p_best_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (have_best && !clear) |=> (best_edp <= $past(best_edp)));

   // R8: a sample equal to the best leaves the best configuration in place
   p_tie_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !clear && have_best && edp_value == best_edp) |=> $stable(best_cfg));

endmodule

// File: rtl/tune_step_select.sv
module tune_step_select
   import cache_tuner_pkg::*;
#(
   parameter int MAX_SET_CODE = 2,
   parameter int MAX_WAY_CODE = 2
) (
   input  tune_phase_t phase,
   input  cache_cfg_t  cur_cfg,
   input  cache_cfg_t  win_cfg,
   input  logic        improved,
   output cache_cfg_t  nxt_cfg,
   output tune_phase_t nxt_phase,
   output logic        finish
);

   localparam logic [1:0] SET_TOP = 2'(MAX_SET_CODE);
   localparam logic [1:0] WAY_TOP = 2'(MAX_WAY_CODE);

   logic can_grow_sets;
   logic can_grow_ways;

   assign can_grow_sets = improved && (cur_cfg.sets < SET_TOP);
   assign can_grow_ways = improved && (cur_cfg.ways < WAY_TOP);

   always_comb begin
      nxt_cfg   = win_cfg;
      nxt_phase = phase;
      finish    = 1'b0;
      unique case (phase)
         PH_BASE: begin
            nxt_cfg      = cur_cfg;
            nxt_cfg.sets = 2'd1;
            nxt_phase    = PH_SETS;
         end
         PH_SETS: begin
            if (can_grow_sets) begin
               nxt_cfg      = cur_cfg;
               nxt_cfg.sets = cur_cfg.sets + 2'd1;
            end else begin
               nxt_cfg      = win_cfg;
               nxt_cfg.line = 1'b1;
               nxt_phase    = PH_LINE;
            end
         end
         PH_LINE: begin
            nxt_cfg      = win_cfg;
            nxt_cfg.ways = 2'd1;
            nxt_phase    = PH_WAYS;
         end
         PH_WAYS: begin
            if (can_grow_ways) begin
               nxt_cfg      = cur_cfg;
               nxt_cfg.ways = cur_cfg.ways + 2'd1;
            end else begin
               nxt_cfg = win_cfg;
               finish  = 1'b1;
            end
         end
         default: begin
            nxt_cfg   = CFG_BASE;
            nxt_phase = PH_BASE;
         end
      endcase
   end

endmodule

// File: rtl/eval_counter.sv
module eval_counter #(
   parameter int CNT_W = 3,
   parameter int LIMIT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT);

   initial begin
      a_limit_fits: assert ((LIMIT > 0) && (LIMIT < (1 << CNT_W)))
         else $error("eval_counter: LIMIT does not fit in CNT_W bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count <= '0;
      else if (clear)               count <= '0;
      else if (inc && count < TOP)  count <= count + 1'b1;
   end

   // R9: the count is bounded by the longest possible walk
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      count <= TOP);

   // R9: each accepted sample advances the count by one
   p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clear && count < TOP) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/greedy_cache_tuner.sv
module greedy_cache_tuner
   import cache_tuner_pkg::*;
#(
   parameter int EDP_W        = 32,
   parameter int MAX_SET_CODE = 2,
   parameter int MAX_WAY_CODE = 2,
   parameter int CNT_W        = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             edp_valid,
   input  logic [EDP_W-1:0] edp_value,
   output logic             edp_ready,
   output logic             meas_req,
   output logic [1:0]       cfg_sets,
   output logic             cfg_line,
   output logic [1:0]       cfg_ways,
   output logic             done,
   output logic [CNT_W-1:0] eval_count
);

   // base + set steps + one line step + way steps
   localparam int MAX_EVALS = 1 + MAX_SET_CODE + 1 + MAX_WAY_CODE;

   initial begin
      a_sets_range: assert (MAX_SET_CODE >= 1 && MAX_SET_CODE <= 2)
         else $error("greedy_cache_tuner: MAX_SET_CODE must be 1 or 2");
      a_ways_range: assert (MAX_WAY_CODE >= 1 && MAX_WAY_CODE <= 2)
         else $error("greedy_cache_tuner: MAX_WAY_CODE must be 1 or 2");
      a_edp_width: assert (EDP_W >= 2)
         else $error("greedy_cache_tuner: EDP_W too small");
      a_cnt_width: assert (MAX_EVALS < (1 << CNT_W))
         else $error("greedy_cache_tuner: CNT_W too small for the walk");
   end

   tune_state_t state;
   tune_phase_t phase;
   cache_cfg_t  cfg;

   logic        accept;
   logic        improved;
   cache_cfg_t  win_cfg;
   cache_cfg_t  nxt_cfg;
   tune_phase_t nxt_phase;
   logic        finish;

   assign accept = (state == ST_WAIT) && edp_valid && !start;

   edp_best_tracker #(
      .EDP_W (EDP_W)
   ) u_best (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start),
      .take      (accept),
      .edp_value (edp_value),
      .cur_cfg   (cfg),
      .improved  (improved),
      .win_cfg   (win_cfg)
   );

   tune_step_select #(
      .MAX_SET_CODE (MAX_SET_CODE),
      .MAX_WAY_CODE (MAX_WAY_CODE)
   ) u_step (
      .phase     (phase),
      .cur_cfg   (cfg),
      .win_cfg   (win_cfg),
      .improved  (improved),
      .nxt_cfg   (nxt_cfg),
      .nxt_phase (nxt_phase),
      .finish    (finish)
   );

   eval_counter #(
      .CNT_W (CNT_W),
      .LIMIT (MAX_EVALS)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .inc   (accept),
      .count (eval_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         phase <= PH_BASE;
         cfg   <= CFG_BASE;
      end else if (start) begin
         state <= ST_LAUNCH;
         phase <= PH_BASE;
         cfg   <= CFG_BASE;
      end else begin
         unique case (state)
            ST_LAUNCH: state <= ST_WAIT;
            ST_WAIT: begin
               if (edp_valid) begin
                  cfg   <= nxt_cfg;
                  phase <= nxt_phase;
                  state <= finish ? ST_DONE : ST_LAUNCH;
               end
            end
            default: state <= state;
         endcase
      end
   end

   assign meas_req  = (state == ST_LAUNCH);
   assign edp_ready = (state == ST_WAIT);
   assign done      = (state == ST_DONE);
   assign cfg_sets  = cfg.sets;
   assign cfg_line  = cfg.line;
   assign cfg_ways  = cfg.ways;

   // R1 / R11: a start pulse always restarts from the base configuration
   p_start_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (meas_req && !done && eval_count == '0
                 && cfg_sets == 2'd0 && !cfg_line && cfg_ways == 2'd0));

   // R2: unused codes never reach the caches
   p_legal_codes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sets != 2'd3) && (cfg_ways != 2'd3));

   // R3: request is a single-cycle pulse followed by the wait for a sample
   p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_req && !start) |=> (!meas_req && edp_ready));

   // R3: waiting for a sample holds until one is accepted
   p_ready_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (edp_ready && !edp_valid && !start) |=> (edp_ready && !meas_req));

   // R4: configuration is frozen across a measurement interval
   p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((meas_req || (edp_ready && !edp_valid)) && !start)
         |=> $stable({cfg_sets, cfg_line, cfg_ways}));

   // R10: finished state and result persist until restarted
   p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && !meas_req && !edp_ready
                            && $stable({cfg_sets, cfg_line, cfg_ways})
                            && $stable(eval_count)));

endmodule

// File: tb/sim_greedy_cache_tuner.sv
module sim_greedy_cache_tuner;

   localparam int EDP_W = 32;
   localparam int CNT_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             edp_valid = 1'b0;
   logic [EDP_W-1:0] edp_value = '0;
   logic             edp_ready;
   logic             meas_req;
   logic [1:0]       cfg_sets;
   logic             cfg_line;
   logic [1:0]       cfg_ways;
   logic             done;
   logic [CNT_W-1:0] eval_count;

   greedy_cache_tuner #(
      .EDP_W (EDP_W),
      .CNT_W (CNT_W)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .edp_valid  (edp_valid),
      .edp_value  (edp_value),
      .edp_ready  (edp_ready),
      .meas_req   (meas_req),
      .cfg_sets   (cfg_sets),
      .cfg_line   (cfg_line),
      .cfg_ways   (cfg_ways),
      .done       (done),
      .eval_count (eval_count)
   );

   always #10 clk = ~clk;   // 50 MHz

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   int         tbl [0:17];
   logic [4:0] exp_seq [0:7];
   int         exp_n;
   logic [4:0] exp_final;

   wire [4:0] cfg_bus = {cfg_sets, cfg_line, cfg_ways};

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         checks = checks + 1;
         fails  = fails + 1;
         $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
      end
   endtask

   // index of a configuration code {sets,line,ways} into the EDP table
   function automatic int tix(input logic [4:0] c);
      return int'(c[4:3]) * 6 + int'(c[2]) * 3 + int'(c[1:0]);
   endfunction

   task automatic push(input logic [4:0] c);
      exp_seq[exp_n] = c;
      exp_n = exp_n + 1;
   endtask

   // expected greedy walk derived from the requirements R5..R8
   task automatic model();
      logic [4:0] cur;
      logic [4:0] bc;
      int best;
      exp_n = 0;
      cur = 5'b00000; push(cur); best = tbl[tix(cur)]; bc = cur;
      cur = 5'b01000; push(cur);
      if (tbl[tix(cur)] < best) begin
         best = tbl[tix(cur)]; bc = cur;
         cur = 5'b10000; push(cur);
         if (tbl[tix(cur)] < best) begin best = tbl[tix(cur)]; bc = cur; end
      end
      cur = bc | 5'b00100; push(cur);
      if (tbl[tix(cur)] < best) begin best = tbl[tix(cur)]; bc = cur; end
      cur = bc | 5'b00001; push(cur);
      if (tbl[tix(cur)] < best) begin
         best = tbl[tix(cur)]; bc = cur;
         cur = {bc[4:2], 2'd2}; push(cur);
         if (tbl[tix(cur)] < best) begin best = tbl[tix(cur)]; bc = cur; end
      end
      exp_final = bc;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   // called at a negedge with meas_req high; answers with the table value
   task automatic answer(input int gap);
      logic [4:0] held;
      held = cfg_bus;
      @(negedge clk);
      chk(edp_ready == 1'b1, "R3", "ready after request", int'(edp_ready), 1);
      for (int g = 0; g < gap; g++) begin
         chk(cfg_bus == held, "R4", "config held in interval", int'(cfg_bus), int'(held));
         chk(meas_req == 1'b0, "R3", "no request while waiting", int'(meas_req), 0);
         @(negedge clk);
      end
      edp_valid = 1'b1;
      edp_value = EDP_W'(tbl[tix(cfg_bus)]);
      @(negedge clk);
      edp_valid = 1'b0;
   endtask

   task automatic wait_req();
      for (int g = 0; g < 50 && !meas_req && !done; g++) @(negedge clk);
   endtask

   task automatic run_trial(input int abort_at);
      int k;
      model();
      pulse_start();
      if (abort_at > 0) begin
         for (int a = 0; a < abort_at; a++) begin
            wait_req();
            answer(0);
         end
         @(negedge clk);   // now waiting for a sample
         pulse_start();
         chk(cfg_bus == 5'b0, "R11", "config after restart", int'(cfg_bus), 0);
         chk(eval_count == '0, "R11", "count after restart", int'(eval_count), 0);
         chk(meas_req && !done, "R11", "request after restart", int'(meas_req), 1);
      end else begin
         chk(meas_req == 1'b1, "R1", "request after start", int'(meas_req), 1);
         chk(cfg_bus == 5'b0, "R1", "base config", int'(cfg_bus), 0);
      end
      k = 0;
      while (k < 8) begin
         wait_req();
         if (done) break;
         if (k < exp_n)
            chk(cfg_bus == exp_seq[k], "R5 R6 R7", "visited config",
                int'(cfg_bus), int'(exp_seq[k]));
         chk(cfg_sets != 2'd3 && cfg_ways != 2'd3, "R2", "legal codes", int'(cfg_bus), 0);
         answer($urandom_range(0, 3));
         k = k + 1;
      end
      chk(k == exp_n, "R5 R6 R7", "number of candidates", k, exp_n);
      chk(int'(eval_count) == exp_n, "R9", "evaluation count", int'(eval_count), exp_n);
      chk(eval_count <= 3'd6, "R9", "count bound", int'(eval_count), 6);
      chk(cfg_bus == exp_final, "R8", "chosen config", int'(cfg_bus), int'(exp_final));
      chk(done == 1'b1, "R10", "done raised", int'(done), 1);
      for (int h = 0; h < 4; h++) begin
         @(negedge clk);
         chk(done && !meas_req && !edp_ready && cfg_bus == exp_final, "R10",
             "result held", int'(cfg_bus), int'(exp_final));
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(cfg_bus == 5'b0, "R1", "reset config", int'(cfg_bus), 0);
      chk(!done && !meas_req && !edp_ready, "R1", "reset idle",
          int'({done, meas_req, edp_ready}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(eval_count == '0, "R1", "reset count", int'(eval_count), 0);
      chk(!meas_req && !edp_ready, "R1", "idle until start",
          int'({meas_req, edp_ready}), 0);

      // flat table: every step ties, shortest walk, base kept (R8)
      for (int i = 0; i < 18; i++) tbl[i] = 7;
      run_trial(0);

      // strictly falling with every larger parameter: full walk to {2,1,2}
      for (int s = 0; s < 3; s++)
         for (int l = 0; l < 2; l++)
            for (int w = 0; w < 3; w++)
               tbl[s*6 + l*3 + w] = 100 - 20*s - 9*l - 4*w;
      run_trial(0);
      chk(cfg_bus == 5'b10110, "R5 R7", "deepest config", int'(cfg_bus), 22);

      // restart while a sample is outstanding (R11)
      run_trial(2);

      // line worse, 2 ways better, 4 ways equal: ties stop growth
      for (int i = 0; i < 18; i++) tbl[i] = 50;
      tbl[6] = 40; tbl[12] = 45; tbl[9] = 40; tbl[7] = 30; tbl[8] = 30;
      run_trial(0);

      for (int t = 0; t < 30; t++) begin
         for (int i = 0; i < 18; i++) tbl[i] = int'($urandom_range(0, 15));
         run_trial((t % 5 == 4) ? int'($urandom_range(1, 3)) : 0);
      end

      summary();
      $finish;
   end

endmodule